// File: doc/BRIEF.md
# Serial Register Access Slave Port

This block is the serial slave port of a converter. A host reaches a small register file through four pins: an active-low select, a serial clock that idles high, a data input and a data output. The data output also carries an active-low ready flag. Every access is indirect. The host first shifts in an 8-bit command byte, and that byte picks the direction and the target of the single transfer that follows. The converter core hands each new 16-bit result to the port through a one-cycle parallel strobe. The port then keeps the host's ready indication in step with those results. A result is never changed while it is being shifted out.

All serial pins are oversampled by the system clock. Each pin passes through a synchronizer, and the port detects clock edges in the system clock domain. The host may use the port in three ways:

- Framed, with select marking each transfer.
- 3-wire, with select tied low and the ready state polled through a status register.
- Continuous read, where successive results stream out without repeated commands.

A run of 32 ones on the data input returns the port and every register to the power-on state.

The protocol machine (`ser_proto_fsm`) has four states:

- `ST_CMD`: collects a command byte.
- `ST_WRITE`: collects a register write.
- `ST_READ`: shifts a register out.
- `ST_CWAIT`: in continuous read, waits for a fresh result.

Its transitions are:

- `ST_CMD`→`ST_READ` on an accepted read command.
- `ST_CMD`→`ST_WRITE` on an accepted write to the mode or filter register.
- `ST_CMD`→`ST_CMD` on a rejected command, or on a write to a read-only target.
- `ST_WRITE`→`ST_CMD` after 8 bits.
- `ST_READ`→`ST_CMD` after the last bit, outside continuous read.
- `ST_READ`→`ST_CWAIT` after the last bit in continuous read.
- `ST_CWAIT`→`ST_READ` on a falling clock edge while ready is low.
- Any state→`ST_CMD` or `ST_CWAIT` when select rises mid-word.
- Any state→`ST_CMD` on the ones-run reset.

The result manager (`ser_conv_mgr`) has three states:

- `CV_IDLE`.
- `CV_HOLD`: a result has arrived during a data read and is held back.
- `CV_UPD`: ready is high and the data register loads on the next edge.

Its transitions are:

- `CV_IDLE`→`CV_UPD` on a strobe while no data read is in progress.
- `CV_IDLE`→`CV_HOLD` on a strobe during a data read.
- `CV_HOLD`→`CV_UPD` when the read ends.
- `CV_UPD`→`CV_IDLE` after the load.
- `CV_UPD`→`CV_UPD` or `CV_HOLD` when another strobe lands in the update cycle.

Top module: `ser_reg_slave`

## Requirements
- R1: After reset the ready flag is high, the data register is 0, the mode register is 0x0A and the filter register is 0x04. While cs_n is high, dout_oe is low. The first 8 bits clocked in are always treated as a command.
- R2: Command byte layout:
  - bit 7 must be 0, or the byte is dropped and the next byte is again a command;
  - bit 6 is 1 for read and 0 for write;
  - bits 5:4 select the register: 00 status (read-only), 01 mode, 10 filter, 11 data (read-only);
  - bit 3 requests continuous read;
  - bits 2:0 are ignored.

  A write aimed at status or data has no data phase.
- R3: After an accepted write command to mode or filter, the next 8 bits are stored into that register and can be read back.
- R4: Reads are MSB first: 16 bits for data and 8 bits for the other registers. din is sampled on rising serial clock edges. The first output bit is driven after the command's last rising edge. Each later bit changes on a falling edge.
- R5: The ready flag (dout while no read is shifting) goes low when a new result lands in the data register. It goes high when a complete data-register read finishes.
- R6: On a result strobe while no data read is in progress, ready is driven high for exactly one system clock. The data register then takes the new word and ready goes low.
- R7: A strobe that arrives during a data read does not alter the word being shifted. It is applied after the read finishes, and ready then goes low again.
- R8: Outside continuous read, repeated data reads return the same word even after ready has gone high.
- R9: A data read with bit 3 set (command 0x78) enters continuous read. Each later result is read once with no command, starting on the first falling edge after ready goes low. Clocking while ready is high returns all ones.
- R10: 32 consecutive ones sampled with cs_n low reset the protocol state, clear continuous read, and return all registers and the ready flag to the reset values. A run of 31 ones has no effect.
- R11: Raising cs_n discards a partly shifted command, write or read. The only exception is a read that has been set up but not yet clocked.
- R12: A status read returns the ready flag in bit 7 (0 = new result waiting) and zeros below it. This lets a 3-wire host poll for results.
- R13: A read set up in one frame keeps its first bit. On the next falling edge of cs_n that MSB is on dout before any serial clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select and frame marker |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host, sampled on rising sclk |
| conv_valid | input | 1 | One-cycle strobe: new conversion result |
| conv_data | input | 16 | Conversion result that comes with the strobe |
| dout | output | 1 | Serial read data, or active-low ready when not shifting |
| dout_oe | output | 1 | Drive enable for dout, low while cs_n is high |

## Verification
The bench targets the collisions between the result path and the serial path:

- **Strobe mid-read.** A strobe that lands in the middle of a data read would corrupt the outgoing word, or lose the new result, if the update were not held off.
- **Update glitch.** A strobe while an old word is still unread must give a one-cycle high pulse on ready. Without it, a host could start a read during the update.
- **Ones-run threshold.** The bench tests both sides of the limit. Reset firing on 31 ones, or failing to fire on 32, shows up as wrong mode readback after a run of all-ones command bytes.
- **Select and continuous read.** A port that kept partial bits across a select pulse would misalign the following command. A port that dropped an armed read on select would lose the framed MSB. In continuous read, a port that re-served an old word would return data instead of all ones while ready is high.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

    // Protocol states of the serial port
    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_CWAIT = 2'd3
    } proto_st_e;

    // States of the conversion-result manager
    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_HOLD = 2'd1,
        CV_UPD  = 2'd2
    } conv_st_e;

    // Command byte field positions (decoded by the protocol machine)
    localparam int CMD_WEN_BIT   = 7;
    localparam int CMD_RD_BIT    = 6;
    localparam int CMD_SEL_HI    = 5;
    localparam int CMD_SEL_LO    = 4;
    localparam int CMD_CREAD_BIT = 3;

    // Register select codes
    localparam logic [1:0] SEL_STAT = 2'b00;
    localparam logic [1:0] SEL_MODE = 2'b01;
    localparam logic [1:0] SEL_FILT = 2'b10;
    localparam logic [1:0] SEL_DATA = 2'b11;

endpackage

// File: rtl/ser_pin_sync.sv
module ser_pin_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[i]}};
            end else begin
                chain <= {chain[STAGES-2:0], pin[i]};
            end
        end
        assign lvl[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/ser_conv_mgr.sv
module ser_conv_mgr
    import ser_reg_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          conv_valid,
    input  logic [DW-1:0] conv_data,
    input  logic          busy,
    input  logic          rd_done,
    output logic [DW-1:0] word_fwd,
    output logic          rdy_n
);

    conv_st_e      cv_q, cv_d;
    logic [DW-1:0] data_q, data_d;
    logic [DW-1:0] pend_q, pend_d;
    logic          rdy_q, rdy_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q   <= CV_IDLE;
            data_q <= '0;
            pend_q <= '0;
            rdy_q  <= 1'b1;
        end else begin
            cv_q   <= cv_d;
            data_q <= data_d;
            pend_q <= pend_d;
            rdy_q  <= rdy_d;
        end
    end

    // Next state and outputs
    always_comb begin
        cv_d   = cv_q;
        data_d = data_q;
        pend_d = pend_q;
        rdy_d  = rdy_q;
        if (soft_rst) begin
            cv_d   = CV_IDLE;
            data_d = '0;
            pend_d = '0;
            rdy_d  = 1'b1;
        end else begin
            if (rd_done) rdy_d = 1'b1;
            unique case (cv_q)
                CV_IDLE: begin
                    if (conv_valid) begin
                        pend_d = conv_data;
                        if (busy) begin
                            cv_d = CV_HOLD;
                        end else begin
                            cv_d  = CV_UPD;
                            rdy_d = 1'b1;
                        end
                    end
                end
                CV_HOLD: begin
                    if (conv_valid) pend_d = conv_data;
                    if (!busy) begin
                        cv_d  = CV_UPD;
                        rdy_d = 1'b1;
                    end
                end
                CV_UPD: begin
                    data_d = pend_q;
                    rdy_d  = 1'b0;
                    cv_d   = CV_IDLE;
                    if (conv_valid) begin
                        pend_d = conv_data;
                        if (busy) begin
                            cv_d = CV_HOLD;
                        end else begin
                            cv_d  = CV_UPD;
                            rdy_d = 1'b1;
                        end
                    end
                end
                default: cv_d = CV_IDLE;
            endcase
        end
    end

    // A load in the update cycle takes the word that is about to land
    assign word_fwd = (cv_q == CV_UPD) ? pend_q : data_q;
    assign rdy_n    = rdy_q;

    // R6: the data register only changes after ready has been high
    a_r6_rdy_before_update: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_q) && !$past(soft_rst)) |-> $past(rdy_q));

    // R7: the word is frozen across an ongoing data read
    a_r7_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2) && !$past(soft_rst)) |-> $stable(data_q));

    // R5: a finished data read raises ready
    a_r5_done_raises_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> rdy_q);

endmodule

// File: rtl/ser_proto_fsm.sv
module ser_proto_fsm
    import ser_reg_pkg::*;
#(
    parameter int         DW        = 16,
    parameter int         RW        = 8,
    parameter int         ONES_LEN  = 32,
    parameter logic [7:0] MODE_INIT = 8'h0A,
    parameter logic [7:0] FILT_INIT = 8'h04
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          sclk_lvl,
    input  logic          din_lvl,
    input  logic          rdy_n,
    input  logic [DW-1:0] word_fwd,
    output logic          soft_rst,
    output logic          busy,
    output logic          rd_done,
    output logic          dout
);

    localparam int CW = $clog2(DW + 1);
    localparam int OW = $clog2(ONES_LEN + 1);

    proto_st_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [RW-2:0] sh_in_q, sh_in_d;
    logic [DW-1:0] sh_out_q, sh_out_d;
    logic [1:0]    sel_q, sel_d;
    logic          cread_q, cread_d;
    logic [RW-1:0] mode_q, mode_d;
    logic [RW-1:0] filt_q, filt_d;
    logic [OW-1:0] ones_q, ones_d;
    logic          sclk_prev_q;

    logic          rise, fall, load_data;
    logic [RW-1:0] cmd_word;
    logic [1:0]    cmd_sel;
    logic [DW-1:0] view;
    logic [CW-1:0] last_bit;

    assign rise     = sclk_lvl & ~sclk_prev_q;
    assign fall     = ~sclk_lvl & sclk_prev_q;
    assign cmd_word = {sh_in_q, din_lvl};
    assign cmd_sel  = cmd_word[CMD_SEL_HI:CMD_SEL_LO];
    assign last_bit = (sel_q == SEL_DATA) ? CW'(DW - 1) : CW'(RW - 1);

    // Left-aligned view of the register a read command selects
    always_comb begin
        view = '0;
        unique case (cmd_sel)
            SEL_STAT: view[DW-1]        = rdy_n;
            SEL_MODE: view[DW-1 -: RW]  = mode_q;
            SEL_FILT: view[DW-1 -: RW]  = filt_q;
            SEL_DATA: view              = word_fwd;
            default:  view              = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= ST_CMD;
            cnt_q       <= '0;
            sh_in_q     <= '0;
            sh_out_q    <= '0;
            sel_q       <= SEL_STAT;
            cread_q     <= 1'b0;
            mode_q      <= MODE_INIT;
            filt_q      <= FILT_INIT;
            ones_q      <= '0;
            sclk_prev_q <= 1'b1;
        end else begin
            st_q        <= st_d;
            cnt_q       <= cnt_d;
            sh_in_q     <= sh_in_d;
            sh_out_q    <= sh_out_d;
            sel_q       <= sel_d;
            cread_q     <= cread_d;
            mode_q      <= mode_d;
            filt_q      <= filt_d;
            ones_q      <= ones_d;
            sclk_prev_q <= sclk_lvl;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        sh_in_d   = sh_in_q;
        sh_out_d  = sh_out_q;
        sel_d     = sel_q;
        cread_d   = cread_q;
        mode_d    = mode_q;
        filt_d    = filt_q;
        ones_d    = ones_q;
        soft_rst  = 1'b0;
        rd_done   = 1'b0;
        load_data = 1'b0;

        if (cs_hi)     ones_d = '0;
        else if (rise) ones_d = din_lvl ? ones_q + OW'(1) : '0;

        if (!cs_hi && rise && din_lvl && ones_q == OW'(ONES_LEN - 1)) begin
            soft_rst = 1'b1;
            ones_d   = '0;
            st_d     = ST_CMD;
            cnt_d    = '0;
            sel_d    = SEL_STAT;
            cread_d  = 1'b0;
            mode_d   = MODE_INIT;
            filt_d   = FILT_INIT;
        end else if (cs_hi) begin
            if (!(st_q == ST_READ && cnt_q == '0)) begin
                cnt_d = '0;
                st_d  = cread_q ? ST_CWAIT : ST_CMD;
            end
        end else begin
            unique case (st_q)
                ST_CMD: begin
                    if (rise) begin
                        sh_in_d = cmd_word[RW-2:0];
                        if (cnt_q == CW'(RW - 1)) begin
                            cnt_d = '0;
                            if (!cmd_word[CMD_WEN_BIT]) begin
                                sel_d = cmd_sel;
                                if (cmd_word[CMD_RD_BIT]) begin
                                    st_d      = ST_READ;
                                    sh_out_d  = view;
                                    load_data = (cmd_sel == SEL_DATA);
                                    cread_d   = (cmd_sel == SEL_DATA) && cmd_word[CMD_CREAD_BIT];
                                end else if (cmd_sel == SEL_MODE || cmd_sel == SEL_FILT) begin
                                    st_d = ST_WRITE;
                                end
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_WRITE: begin
                    if (rise) begin
                        sh_in_d = cmd_word[RW-2:0];
                        if (cnt_q == CW'(RW - 1)) begin
                            cnt_d = '0;
                            st_d  = ST_CMD;
                            if (sel_q == SEL_MODE) mode_d = cmd_word;
                            else                   filt_d = cmd_word;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_READ: begin
                    if (rise) begin
                        if (cnt_q == last_bit) begin
                            cnt_d   = '0;
                            st_d    = cread_q ? ST_CWAIT : ST_CMD;
                            rd_done = (sel_q == SEL_DATA);
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end else if (fall && cnt_q != '0) begin
                        sh_out_d = {sh_out_q[DW-2:0], 1'b0};
                    end
                end
                ST_CWAIT: begin
                    if (fall && !rdy_n) begin
                        st_d      = ST_READ;
                        sel_d     = SEL_DATA;
                        sh_out_d  = word_fwd;
                        cnt_d     = '0;
                        load_data = 1'b1;
                    end
                end
                default: st_d = ST_CMD;
            endcase
        end
    end

    assign busy = (st_q == ST_READ && sel_q == SEL_DATA) || load_data;
    assign dout = (st_q == ST_READ) ? sh_out_q[DW-1] : rdy_n;

    // R10: the ones-run reset lands in the command state with initial registers
    a_r10_soft_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st_q == ST_CMD && mode_q == MODE_INIT && filt_q == FILT_INIT && !cread_q));

    // R2: a command byte with its enable bit set leaves the port awaiting a command
    a_r2_rejected_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CMD && rise && !cs_hi && !soft_rst && cnt_q == CW'(RW - 1)
         && sh_in_q[RW-2]) |=> st_q == ST_CMD);

    // R4: the output shifter only moves on a falling serial clock edge
    a_r4_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ && $past(st_q) == ST_READ && !$past(fall)) |-> $stable(sh_out_q));

    // R11: deselection drops any partly shifted word
    a_r11_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi && !(st_q == ST_READ && cnt_q == '0)) |=> cnt_q == '0);

endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave #(
    parameter int         DATA_W      = 16,
    parameter int         REG_W       = 8,
    parameter int         ONES_LEN    = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MODE_INIT   = 8'h0A,
    parameter logic [7:0] FILT_INIT   = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              conv_valid,
    input  logic [DATA_W-1:0] conv_data,
    output logic              dout,
    output logic              dout_oe
);

    localparam int NPIN = 3;

    logic [NPIN-1:0]   pin_lvl;
    logic              soft_rst, busy, rd_done, rdy_n;
    logic [DATA_W-1:0] word_fwd;

    // bit 0 select (idles high), bit 1 serial clock (idles high), bit 2 data in
    ser_pin_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({din, sclk, cs_n}),
        .lvl   (pin_lvl)
    );

    ser_proto_fsm #(
        .DW        (DATA_W),
        .RW        (REG_W),
        .ONES_LEN  (ONES_LEN),
        .MODE_INIT (MODE_INIT),
        .FILT_INIT (FILT_INIT)
    ) u_proto (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (pin_lvl[0]),
        .sclk_lvl (pin_lvl[1]),
        .din_lvl  (pin_lvl[2]),
        .rdy_n    (rdy_n),
        .word_fwd (word_fwd),
        .soft_rst (soft_rst),
        .busy     (busy),
        .rd_done  (rd_done),
        .dout     (dout)
    );

    ser_conv_mgr #(
        .DW (DATA_W)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .busy       (busy),
        .rd_done    (rd_done),
        .word_fwd   (word_fwd),
        .rdy_n      (rdy_n)
    );

    assign dout_oe = ~pin_lvl[0];

endmodule

// File: tb/ser_reg_slave_bench.sv
module ser_reg_slave_bench;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic        conv_valid = 1'b0;
    logic [15:0] conv_data = '0;
    logic        dout, dout_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ser_reg_slave u_ser_reg_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic o);
        @(negedge clk);
        sclk = 1'b0;
        din  = b;
        wait_clk(HALF);
        o    = dout;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic byte_x(input logic [7:0] v, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) bit_x(v[i], r[i]);
    endtask

    task automatic word_rd(output logic [15:0] r);
        for (int i = 15; i >= 0; i--) bit_x(1'b0, r[i]);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_n = v;
        wait_clk(HALF);
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = v;
        @(negedge clk);
        conv_valid = 1'b0;
        wait_clk(4);
    endtask

    task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] r);
        logic [7:0] junk;
        byte_x(cmd, junk);
        byte_x(8'h00, r);
    endtask

    task automatic rd_data(output logic [15:0] r);
        logic [7:0] junk;
        byte_x(8'h70, junk);
        word_rd(r);
    endtask

    task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] v);
        logic [7:0] junk;
        byte_x(cmd, junk);
        byte_x(v, junk);
    endtask

    task automatic t_reset;
        check(dout_oe == 1'b0, "R1 oe low while deselected", 16'(dout_oe), 16'h0);
        set_cs(1'b0);
        check(dout_oe == 1'b1, "R1 oe high when selected", 16'(dout_oe), 16'h1);
        check(dout == 1'b1, "R1 ready high after reset", 16'(dout), 16'h1);
    endtask

    task automatic t_write_read;
        logic [7:0] r;
        rd_reg(8'h50, r);
        check(r == 8'h0A, "R1 mode reset value", 16'(r), 16'h0A);
        rd_reg(8'h60, r);
        check(r == 8'h04, "R1 filter reset value", 16'(r), 16'h04);
        wr_reg(8'h10, 8'h3C);
        rd_reg(8'h50, r);
        check(r == 8'h3C, "R3 mode write/readback", 16'(r), 16'h3C);
        wr_reg(8'h20, 8'hC3);
        rd_reg(8'h60, r);
        check(r == 8'hC3, "R3 filter write/readback", 16'(r), 16'hC3);
    endtask

    task automatic t_bad_cmd;
        logic [7:0] r;
        wr_reg(8'h90, 8'hA5);
        rd_reg(8'h50, r);
        check(r == 8'h3C, "R2 rejected command ignored", 16'(r), 16'h3C);
    endtask

    task automatic t_data_ready;
        logic [15:0] w;
        push(16'hB26D);
        check(dout == 1'b0, "R5 ready low on new word", 16'(dout), 16'h0);
        rd_data(w);
        check(w == 16'hB26D, "R4 data read MSB first", w, 16'hB26D);
        wait_clk(6);
        check(dout == 1'b1, "R5 ready high after read", 16'(dout), 16'h1);
    endtask

    task automatic t_repeat;
        logic [15:0] w;
        rd_data(w);
        check(w == 16'hB26D, "R8 repeat read same word", w, 16'hB26D);
    endtask

    task automatic t_status;
        logic [7:0] r;
        rd_reg(8'h40, r);
        check(r == 8'h80, "R12 status no new word", 16'(r), 16'h80);
        push(16'h1234);
        rd_reg(8'h40, r);
        check(r == 8'h00, "R12 status new word", 16'(r), 16'h00);
    endtask

    task automatic t_upd_glitch;
        logic [15:0] w;
        @(negedge clk);
        conv_valid = 1'b1;
        conv_data  = 16'h4321;
        @(negedge clk);
        conv_valid = 1'b0;
        check(dout == 1'b1, "R6 ready high before update", 16'(dout), 16'h1);
        @(negedge clk);
        check(dout == 1'b0, "R6 ready low after update", 16'(dout), 16'h0);
        rd_data(w);
        check(w == 16'h4321, "R6 updated word", w, 16'h4321);
    endtask

    task automatic t_hold;
        logic [7:0]  junk;
        logic [15:0] w;
        byte_x(8'h70, junk);
        for (int i = 15; i >= 0; i--) begin
            if (i == 10) push(16'h0F0F);
            bit_x(1'b0, w[i]);
        end
        check(w == 16'h4321, "R7 word unchanged during read", w, 16'h4321);
        wait_clk(20);
        check(dout == 1'b0, "R7 held word applied", 16'(dout), 16'h0);
        rd_data(w);
        check(w == 16'h0F0F, "R7 held word value", w, 16'h0F0F);
    endtask

    task automatic t_cs_discard;
        logic       o;
        logic [7:0] r;
        bit_x(1'b0, o);
        bit_x(1'b0, o);
        bit_x(1'b0, o);
        bit_x(1'b1, o);
        set_cs(1'b1);
        check(dout_oe == 1'b0, "R11 oe low on deselect", 16'(dout_oe), 16'h0);
        set_cs(1'b0);
        rd_reg(8'h50, r);
        check(r == 8'h3C, "R11 partial command discarded", 16'(r), 16'h3C);
    endtask

    task automatic t_framed;
        logic [7:0]  junk;
        logic [15:0] w;
        push(16'h9ABC);
        byte_x(8'h70, junk);
        set_cs(1'b1);
        set_cs(1'b0);
        check(dout == 1'b1, "R13 MSB on select fall", 16'(dout), 16'h1);
        word_rd(w);
        check(w == 16'h9ABC, "R13 framed read word", w, 16'h9ABC);
    endtask

    task automatic t_cread;
        logic [7:0]  junk;
        logic [15:0] w;
        push(16'h1357);
        byte_x(8'h78, junk);
        word_rd(w);
        check(w == 16'h1357, "R9 first continuous word", w, 16'h1357);
        wait_clk(6);
        check(dout == 1'b1, "R9 ready high after read", 16'(dout), 16'h1);
        word_rd(w);
        check(w == 16'hFFFF, "R9 no second read of a word", w, 16'hFFFF);
        push(16'h2468);
        check(dout == 1'b0, "R9 ready low on next word", 16'(dout), 16'h0);
        word_rd(w);
        check(w == 16'h2468, "R9 next word without command", w, 16'h2468);
    endtask

    task automatic t_ones;
        logic        o;
        logic [7:0]  r;
        logic [15:0] w;
        for (int i = 0; i < 32; i++) bit_x(1'b1, o);
        wait_clk(4);
        check(dout == 1'b1, "R10 ready high after ones reset", 16'(dout), 16'h1);
        rd_reg(8'h50, r);
        check(r == 8'h0A, "R10 mode back to reset value", 16'(r), 16'h0A);
        rd_data(w);
        check(w == 16'h0000, "R10 data cleared", w, 16'h0000);
        wr_reg(8'h10, 8'h3C);
        for (int i = 0; i < 31; i++) bit_x(1'b1, o);
        bit_x(1'b0, o);
        rd_reg(8'h50, r);
        check(r == 8'h3C, "R10 31 ones no reset", 16'(r), 16'h3C);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_read();
        t_bad_cmd();
        t_data_ready();
        t_repeat();
        t_status();
        t_upd_glitch();
        t_hold();
        t_cs_discard();
        t_framed();
        t_cread();
        t_ones();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule